// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is a single compare-match timer channel. It holds an up-counter, a compare register and a control/status word. It also holds a shared start/stop word in which the channel owns one bit, and only that bit gates its counting. The counter advances on a prescaled version of a slow timer strobe (`slow_tick`). When the count equals the compare value, the next count tick returns it to zero and latches a sticky match flag. When the matching enable bit is set, that flag drives the interrupt output until software clears it.

Software reaches the registers through a plain synchronous port: one write strobe, one byte address, a select between the channel space and the shared start/stop word, and a combinational read path. Counter writes cross into the slow timer domain. They only take hold after two slow strobes, and until then reads keep showing the old count. Compare writes act at once. The default build is the wide variant: a 32-bit counter, a 16-bit control word and a divide-by-8 prescaler. With `WIDE` = 0 the block becomes the narrow variant: a 16-bit counter, the flag at bit 7 and divide-by-512.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset the control word, the counter and the shared start/stop word read 0, the compare register reads all ones, and `irq` is low.
- R2: In the wide variant, byte address 0 reaches the control word, 4 reaches the counter and 8 reaches the compare register (register index shifted left by 2; by 1 in the narrow variant). Any other channel address reads 0.
- R3: With `bus_glb` = 1, a write stores all START_W bits of the shared start/stop word, and a read returns them unchanged. Only bit CHAN_BIT (default 0) lets the counter run, and the other bits have no effect on this channel.
- R4: While running, the counter advances once per 8 `slow_tick` strobes (512 in the narrow variant). Stopping the channel holds the count and restarts the prescaler phase from zero.
- R5: On a count tick with count equal to compare, the counter goes to 0 and the match flag (control bit 15 wide, bit 7 narrow) is set, so one period lasts compare+1 count ticks.
- R6: The match flag is sticky. A control write with bit 15 = 0 clears it, a write with bit 15 = 1 leaves it unchanged, and the other writable bits take the written value. A match in the same cycle as a clearing write leaves the flag set.
- R7: In the wide variant, control bit 14 is set when the counter rolls over from all ones to zero without a match, and it is cleared the same way as bit 15.
- R8: A counter write becomes visible on reads, and takes over the count, on the second `slow_tick` strobe after the write, whether the channel runs or not. Until then the old value reads back, and a second write before that point restarts the delay.
- R9: `irq` is high exactly while the match flag and the enable bit (control bit 5 wide, bit 6 narrow) are both set. Writing 0 to the control word drops `irq`, and later matches then set the flag without raising `irq`.
- R10: A compare write takes effect at once. A compare value below the current count lets the counter run up to all ones and wrap (setting bit 14) before it matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe of the slow timer clock |
| bus_wr | input | 1 | Register write strobe |
| bus_glb | input | 1 | 1 selects the shared start/stop word, 0 the channel registers |
| bus_addr | input | ADDR_W (4) | Byte address inside the channel space |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for the current address, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
Timing drives most of the bench. It steps the slow strobe one cycle at a time and reads the counter on both sides of each prescaler boundary. A divider that is off by one, or that keeps its phase across a stop, shows up as a count one tick early or late. Counter writes are read back after zero, one and two strobes, and then again after a rewrite in the middle of the delay. A design that applies the write on the first strobe, or lets the first write finish through the second, returns the wrong value there. One cycle carries both a match and a flag-clearing write: a design where the clear wins loses an interrupt. A compare value set below a count near all ones must show the rollover flag before the match flag, and a design that matches on "count >= compare" would set the match flag at once.

// File: rtl/cmt_pkg.sv
// Package: shared register index encoding for the compare-match timer.
// Assumes: channel registers sit at word indices 0..2; the byte stride is
// applied by the top module.
package cmt_pkg;

    typedef enum logic [1:0] {
        IDX_CTRL = 2'd0,
        IDX_CNT  = 2'd1,
        IDX_CMP  = 2'd2,
        IDX_NONE = 2'd3
    } reg_idx_e;

    // Map a byte address to a register index for a given stride shift.
    function automatic reg_idx_e decode_idx(input logic [15:0] byte_addr,
                                            input int unsigned shift);
        logic [15:0] word;
        logic [15:0] low_mask;
        reg_idx_e    r;
        low_mask = (16'd1 << shift) - 16'd1;
        word     = byte_addr >> shift;
        r        = IDX_NONE;
        if ((byte_addr & low_mask) == 16'd0) begin
            case (word)
                16'd0:   r = IDX_CTRL;
                16'd1:   r = IDX_CNT;
                16'd2:   r = IDX_CMP;
                default: r = IDX_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/cmt_prescale.sv
// Module: cmt_prescale
// Divides the slow timer strobe by DIV while the channel runs and emits one
// count tick per DIV strobes. Assumes slow_tick_i is a single-cycle strobe.
// While stopped, the phase counter is held at zero so every restart begins
// a full division period.
module cmt_prescale #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic slow_tick_i,
    output logic tick_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    // Fires on the strobe that completes a division period.
    assign tick_o = run_i && slow_tick_i && (div_q == LAST);

    // Advances the phase on each strobe while running, clears it when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run_i) begin
            div_q <= '0;
        end else if (slow_tick_i) begin
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
        end
    end

    // R4: a stopped channel always restarts from phase zero.
    p_phase_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (div_q == '0))
        else $error("prescaler phase not cleared while stopped");

endmodule

// File: rtl/cmt_count_core.sv
// Module: cmt_count_core
// Holds the up-counter, the compare register and the slow-domain delay for
// software writes to the counter. Assumes tick_i comes from the prescaler and
// slow_tick_i from the slow timer strobe. A counter write is parked and is
// applied on the SYNC_TICKS-th slow strobe after it; an applied write beats a
// count tick in the same cycle.
module cmt_count_core #(
    parameter int CNT_W      = 32,
    parameter int SYNC_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick_i,
    input  logic             tick_i,
    input  logic             wr_cnt_i,
    input  logic             wr_cmp_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             match_o,
    output logic             wrap_o
);
    localparam int AW = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;
    localparam logic [AW-1:0] AGE_LAST = AW'(SYNC_TICKS - 1);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] cmp_q;
    logic             pend_q;
    logic [CNT_W-1:0] pend_val_q;
    logic [AW-1:0]    age_q;
    logic             apply_w;
    logic             hit_w;

    // Parked value lands on the last required strobe unless rewritten now.
    assign apply_w = pend_q && slow_tick_i && (age_q == AGE_LAST) && !wr_cnt_i;
    assign hit_w   = (count_q == cmp_q);
    assign match_o = tick_i && !apply_w && hit_w;
    assign wrap_o  = tick_i && !apply_w && !hit_w && (count_q == ALL_ONES);
    assign count_o = count_q;
    assign cmp_o   = cmp_q;

    // Tracks a parked counter write and its age in slow strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_val_q <= '0;
            age_q      <= '0;
        end else if (wr_cnt_i) begin
            pend_q     <= 1'b1;
            pend_val_q <= wdata_i;
            age_q      <= '0;
        end else if (pend_q && slow_tick_i) begin
            if (apply_w) begin
                pend_q <= 1'b0;
            end else begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    // Loads a matured write, otherwise counts and restarts on compare hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (apply_w) begin
            count_q <= pend_val_q;
        end else if (tick_i) begin
            count_q <= hit_w ? '0 : count_q + 1'b1;
        end
    end

    // Compare register: takes software writes at once, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= ALL_ONES;
        end else if (wr_cmp_i) begin
            cmp_q <= wdata_i;
        end
    end

    // R4: without a tick or a matured write the count does not move.
    p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !apply_w) |=> $stable(count_q))
        else $error("counter moved without a tick");

    // R5: a tick on a compare hit returns the counter to zero.
    p_match_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> (count_q == '0))
        else $error("counter not zero after match");

    // R8: a matured write loads exactly the parked value.
    p_apply_val_r8: assert property (@(posedge clk) disable iff (!rst_n)
        apply_w |=> (count_q == $past(pend_val_q)))
        else $error("parked counter write not applied");

endmodule

// File: rtl/cmt_csr.sv
// Module: cmt_csr
// Control/status word with sticky hardware flags. Assumes match_i and wrap_i
// are single-cycle pulses from the counter core. Software can only clear a
// flag (write 0 to it); writing 1 keeps its state. A hardware set in the same
// cycle as a clearing write wins. OVF_EN picks whether a rollover flag exists.
module cmt_csr #(
    parameter int CTRL_W   = 16,
    parameter int FLAG_BIT = 15,
    parameter bit OVF_EN   = 1'b1,
    parameter int OVF_BIT  = 14,
    parameter int IE_BIT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              match_i,
    input  logic              wrap_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              irq_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [CTRL_W-1:0] ctrl_nxt;
    logic              flag_nxt;
    logic              ovf_nxt;

    // Match flag: cleared only by a written 0, set by hardware.
    assign flag_nxt = (ctrl_q[FLAG_BIT] & (wr_ctrl_i ? wdata_i[FLAG_BIT] : 1'b1))
                      | match_i;

    // Rollover flag only exists in the variant that has one.
    generate
        if (OVF_EN) begin : g_ovf
            assign ovf_nxt = (ctrl_q[OVF_BIT] & (wr_ctrl_i ? wdata_i[OVF_BIT] : 1'b1))
                             | wrap_i;
        end else begin : g_no_ovf
            assign ovf_nxt = wr_ctrl_i ? wdata_i[OVF_BIT] : ctrl_q[OVF_BIT];
        end
    endgenerate

    // Next control word: written bits, then flag bits overlaid.
    always_comb begin
        ctrl_nxt = wr_ctrl_i ? wdata_i : ctrl_q;
        ctrl_nxt[OVF_BIT]  = ovf_nxt;
        ctrl_nxt[FLAG_BIT] = flag_nxt;
    end

    // Control register state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_nxt;
        end
    end

    assign ctrl_o = ctrl_q;
    assign irq_o  = ctrl_q[FLAG_BIT] & ctrl_q[IE_BIT];

    // R5: a match pulse always leaves the flag set.
    p_match_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> ctrl_q[FLAG_BIT])
        else $error("match did not set the flag");

    // R6: a set flag survives every cycle without a clearing write.
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[FLAG_BIT] && !(wr_ctrl_i && !wdata_i[FLAG_BIT])) |=> ctrl_q[FLAG_BIT])
        else $error("match flag dropped on its own");

    // R9: irq never stays up across a write of zero to the word.
    p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_i && (wdata_i == '0) && !match_i) |=> !irq_o)
        else $error("irq survived a zero control write");

endmodule

// File: rtl/cmp_timer_chan.sv
// Module: cmp_timer_chan (top)
// One compare-match timer channel plus the shared start/stop word. Decodes a
// byte-addressed register port, gates the prescaler with this channel's start
// bit, and drives a level interrupt. Assumes one access per cycle, reads are
// combinational, and WIDE picks the 32-bit (1) or 16-bit (0) counter variant.
module cmp_timer_chan #(
    parameter bit WIDE       = 1'b1,
    parameter int START_W    = 8,
    parameter int CHAN_BIT   = 0,
    parameter int ADDR_W     = 4,
    parameter int SYNC_TICKS = 2,
    localparam int CNT_W     = WIDE ? 32 : 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_wr,
    input  logic              bus_glb,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    import cmt_pkg::*;

    localparam int CTRL_W    = 16;
    localparam int CNT_SHIFT = WIDE ? 2 : 1;
    localparam int DIV       = WIDE ? 8 : 512;
    localparam int FLAG_BIT  = WIDE ? 15 : 7;
    localparam int OVF_BIT   = 14;
    localparam int IE_BIT    = WIDE ? 5 : 6;

    reg_idx_e           idx_w;
    logic [START_W-1:0] start_q;
    logic               run_w;
    logic               tick_w;
    logic               wr_ctrl_w;
    logic               wr_cnt_w;
    logic               wr_cmp_w;
    logic               match_w;
    logic               wrap_w;
    logic [CNT_W-1:0]   count_w;
    logic [CNT_W-1:0]   cmp_w;
    logic [CTRL_W-1:0]  ctrl_w;

    assign idx_w     = decode_idx(16'(bus_addr), CNT_SHIFT);
    assign wr_ctrl_w = bus_wr && !bus_glb && (idx_w == IDX_CTRL);
    assign wr_cnt_w  = bus_wr && !bus_glb && (idx_w == IDX_CNT);
    assign wr_cmp_w  = bus_wr && !bus_glb && (idx_w == IDX_CMP);
    assign run_w     = start_q[CHAN_BIT];

    // Shared start/stop word: every bit is stored, only ours is used here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (bus_wr && bus_glb) begin
            start_q <= bus_wdata[START_W-1:0];
        end
    end

    cmt_prescale #(
        .DIV (DIV)
    ) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_w),
        .slow_tick_i (slow_tick),
        .tick_o      (tick_w)
    );

    cmt_count_core #(
        .CNT_W      (CNT_W),
        .SYNC_TICKS (SYNC_TICKS)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick_i (slow_tick),
        .tick_i      (tick_w),
        .wr_cnt_i    (wr_cnt_w),
        .wr_cmp_i    (wr_cmp_w),
        .wdata_i     (bus_wdata),
        .count_o     (count_w),
        .cmp_o       (cmp_w),
        .match_o     (match_w),
        .wrap_o      (wrap_w)
    );

    cmt_csr #(
        .CTRL_W   (CTRL_W),
        .FLAG_BIT (FLAG_BIT),
        .OVF_EN   (WIDE),
        .OVF_BIT  (OVF_BIT),
        .IE_BIT   (IE_BIT)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl_i (wr_ctrl_w),
        .wdata_i   (bus_wdata[CTRL_W-1:0]),
        .match_i   (match_w),
        .wrap_i    (wrap_w),
        .ctrl_o    (ctrl_w),
        .irq_o     (irq)
    );

    // Read path: select by global flag, then by decoded register index.
    always_comb begin
        bus_rdata = '0;
        if (bus_glb) begin
            bus_rdata[START_W-1:0] = start_q;
        end else begin
            case (idx_w)
                IDX_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_w;
                IDX_CNT:  bus_rdata = count_w;
                IDX_CMP:  bus_rdata = cmp_w;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R3: a cleared start bit keeps the prescaler from ever ticking.
    p_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q[CHAN_BIT] |-> !tick_w)
        else $error("tick while channel stopped");

endmodule

// File: tb/sim_cmp_timer_chan.sv
`timescale 1ns/1ps
module sim_cmp_timer_chan;
    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_CNT  = 4'd4;
    localparam logic [3:0] A_CMP  = 4'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_glb = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    cmp_timer_chan u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .bus_wr    (bus_wr),
        .bus_glb   (bus_glb),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic glb, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_glb = glb; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_glb = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic glb, input logic [3:0] a,
                          input logic [31:0] exp);
        @(negedge clk);
        bus_glb = glb; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
        bus_glb = 1'b0;
    endtask

    task automatic irq_chk(input string req, input logic exp);
        @(negedge clk);
        #1;
        chk(req, {31'd0, irq}, {31'd0, exp});
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            slow_tick = 1'b1;
        end
        @(negedge clk);
        slow_tick = 1'b0;
    endtask

    // Load the counter while stopped: write, then two slow strobes.
    task automatic load_cnt(input logic [31:0] v);
        wr(1'b0, A_CNT, v);
        strobe(2);
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", 1'b0, A_CTRL, 32'h0);
        rd_chk("R1 count", 1'b0, A_CNT, 32'h0);
        rd_chk("R1 compare", 1'b0, A_CMP, 32'hFFFF_FFFF);
        rd_chk("R1 start", 1'b1, 4'd0, 32'h0);
        irq_chk("R1 irq", 1'b0);
    endtask

    task automatic t_addr;
        wr(1'b0, A_CMP, 32'h0000_1234);
        rd_chk("R2 compare at byte 8", 1'b0, A_CMP, 32'h0000_1234);
        wr(1'b0, A_CTRL, 32'h0000_0300);
        rd_chk("R2 ctrl at byte 0", 1'b0, A_CTRL, 32'h0000_0300);
        rd_chk("R2 count at byte 4", 1'b0, A_CNT, 32'h0);
        rd_chk("R2 unmapped byte 12", 1'b0, 4'd12, 32'h0);
        rd_chk("R2 unmapped byte 2", 1'b0, 4'd2, 32'h0);
        wr(1'b0, A_CTRL, 32'h0);
        wr(1'b0, A_CMP, 32'hFFFF_FFFF);
    endtask

    task automatic t_start_div;
        wr(1'b1, 4'd0, 32'h0000_000A);
        strobe(16);
        rd_chk("R3 other bits do not start", 1'b0, A_CNT, 32'h0);
        rd_chk("R3 start readback", 1'b1, 4'd0, 32'h0000_000A);
        wr(1'b1, 4'd0, 32'h0000_000B);
        rd_chk("R3 start readback own bit", 1'b1, 4'd0, 32'h0000_000B);
        strobe(16);
        rd_chk("R4 two ticks per 16 strobes", 1'b0, A_CNT, 32'd2);
        strobe(7);
        rd_chk("R4 seven strobes no tick", 1'b0, A_CNT, 32'd2);
        strobe(1);
        rd_chk("R4 eighth strobe ticks", 1'b0, A_CNT, 32'd3);
        strobe(5);
        wr(1'b1, 4'd0, 32'h0000_000A);
        strobe(8);
        rd_chk("R3 stopped holds count", 1'b0, A_CNT, 32'd3);
        wr(1'b1, 4'd0, 32'h0000_000B);
        strobe(7);
        rd_chk("R4 phase restarted after stop", 1'b0, A_CNT, 32'd3);
        strobe(1);
        rd_chk("R4 tick after full period", 1'b0, A_CNT, 32'd4);
        wr(1'b1, 4'd0, 32'h0000_000A);
    endtask

    task automatic t_cnt_delay;
        wr(1'b0, A_CNT, 32'h100);
        rd_chk("R8 old value right after write", 1'b0, A_CNT, 32'd4);
        strobe(1);
        rd_chk("R8 old value after one strobe", 1'b0, A_CNT, 32'd4);
        strobe(1);
        rd_chk("R8 new value after two strobes", 1'b0, A_CNT, 32'h100);
        wr(1'b0, A_CNT, 32'h200);
        strobe(1);
        wr(1'b0, A_CNT, 32'h300);
        strobe(1);
        rd_chk("R8 rewrite restarts delay", 1'b0, A_CNT, 32'h100);
        strobe(1);
        rd_chk("R8 second write lands", 1'b0, A_CNT, 32'h300);
    endtask

    task automatic t_match;
        load_cnt(32'h0);
        wr(1'b0, A_CMP, 32'd3);
        wr(1'b0, A_CTRL, 32'h0020);
        wr(1'b1, 4'd0, 32'h0000_000B);
        strobe(24);
        rd_chk("R5 count reaches compare", 1'b0, A_CNT, 32'd3);
        rd_chk("R5 no flag before wrap", 1'b0, A_CTRL, 32'h0020);
        irq_chk("R9 irq low before match", 1'b0);
        strobe(8);
        rd_chk("R5 count zero after match", 1'b0, A_CNT, 32'd0);
        rd_chk("R5 flag set", 1'b0, A_CTRL, 32'h8020);
        irq_chk("R9 irq high on flag and enable", 1'b1);
        strobe(32);
        rd_chk("R5 period is compare+1", 1'b0, A_CNT, 32'd0);
        rd_chk("R6 flag stays set", 1'b0, A_CTRL, 32'h8020);
        wr(1'b0, A_CTRL, 32'h0020);
        rd_chk("R6 write 0 clears flag", 1'b0, A_CTRL, 32'h0020);
        irq_chk("R9 irq low after clear", 1'b0);
        wr(1'b0, A_CTRL, 32'h8320);
        rd_chk("R6 software cannot set flag", 1'b0, A_CTRL, 32'h0320);
        wr(1'b0, A_CTRL, 32'h0020);
        strobe(32);
        irq_chk("R9 irq back after next match", 1'b1);
        wr(1'b0, A_CTRL, 32'h0);
        rd_chk("R9 zero write clears word", 1'b0, A_CTRL, 32'h0);
        irq_chk("R9 zero write drops irq", 1'b0);
        strobe(32);
        rd_chk("R9 flag without enable", 1'b0, A_CTRL, 32'h8000);
        irq_chk("R9 irq masked", 1'b0);
        wr(1'b1, 4'd0, 32'h0000_000A);
    endtask

    task automatic t_collide;
        load_cnt(32'h0);
        wr(1'b0, A_CMP, 32'd1);
        wr(1'b0, A_CTRL, 32'h0020);
        wr(1'b1, 4'd0, 32'h0000_000B);
        strobe(16);
        rd_chk("R5 flag after short period", 1'b0, A_CTRL, 32'h8020);
        strobe(8);
        strobe(7);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h0020; slow_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; slow_tick = 1'b0;
        rd_chk("R6 match beats clearing write", 1'b0, A_CTRL, 32'h8020);
        rd_chk("R5 count zero at collision", 1'b0, A_CNT, 32'd0);
        wr(1'b1, 4'd0, 32'h0000_000A);
    endtask

    task automatic t_wrap;
        wr(1'b0, A_CMP, 32'd5);
        load_cnt(32'hFFFF_FFFE);
        rd_chk("R8 load near max", 1'b0, A_CNT, 32'hFFFF_FFFE);
        wr(1'b0, A_CTRL, 32'h0020);
        wr(1'b1, 4'd0, 32'h0000_000B);
        strobe(8);
        rd_chk("R10 counts past compare", 1'b0, A_CNT, 32'hFFFF_FFFF);
        rd_chk("R10 no flag yet", 1'b0, A_CTRL, 32'h0020);
        strobe(8);
        rd_chk("R10 rolled to zero", 1'b0, A_CNT, 32'd0);
        rd_chk("R7 rollover flag only", 1'b0, A_CTRL, 32'h4020);
        irq_chk("R7 rollover alone no irq", 1'b0);
        strobe(40);
        rd_chk("R10 reaches compare after wrap", 1'b0, A_CNT, 32'd5);
        strobe(8);
        rd_chk("R10 match after wrap", 1'b0, A_CTRL, 32'hC020);
        wr(1'b0, A_CTRL, 32'h0020);
        rd_chk("R7 both flags cleared", 1'b0, A_CTRL, 32'h0020);
        wr(1'b1, 4'd0, 32'h0000_000A);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_addr();
        t_start_div();
        t_cnt_delay();
        t_match();
        t_collide();
        t_wrap();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule